// File: doc/BRIEF.md
# Frequency-Based Page Replacement Unit

This block keeps the replacement bookkeeping for a small, fully associative set of page frames. Each cycle it can accept one page-number reference. One cycle later it reports whether the page was resident (hit) or not (fault), which frame holds or now receives the page, and, when a resident page had to be displaced, which page that was. It also keeps a running count of faults. It moves no data and holds no memory tags. It only decides where a page lives.

Each frame holds a page number, a valid flag, a use counter and a load stamp. The load stamp comes from a sequence number that advances on every load. When all frames are occupied, the victim is picked by use count. A mode input selects whether the lowest count (least-frequently-used) or the highest count (most-frequently-used) is evicted. Among equal counts, the page loaded earliest goes. An optional decay input halves every count periodically, so pages that were busy long ago lose their standing.

Top module: `freq_page_repl`

## Requirements
- R1: A reference to a resident page gives res_hit=1, reports the frame holding it, sets res_evict=0, leaves fault_count unchanged, and raises that page's count by one.
- R2: A fault while any frame is empty loads the page into the lowest-indexed empty frame with count 1, and reports no eviction.
- R3: With mode_mfu=0, a fault with every frame occupied evicts the page with the smallest count and reports it on res_victim with res_evict=1.
- R4: With mode_mfu=1, a fault with every frame occupied evicts the page with the largest count.
- R5: When several pages share the deciding count, the page that was loaded earliest is evicted. With 3 frames and mode_mfu=0, the references 7,0,1,2,0,3,0,4,0,3,0,2 produce exactly 7 faults.
- R6: The results for a reference accepted at a clock edge appear right after that edge and stay for one cycle. res_valid is 1 exactly in the cycle after ref_valid was 1.
- R7: fault_count rises by exactly one on each fault and holds on each hit.
- R8: Counts saturate at 2^CNT_W-1 and never wrap.
- R9: While decay_en is 1, every DECAY_PERIOD-th cycle halves every count of a resident page, with a floor of 1. If a hit falls on that cycle, its page ends at the halved value plus one. The victim in that cycle is chosen from the counts before halving.
- R10: A synchronous reset (rst=1) empties all frames, clears fault_count and res_valid, and restarts loading at frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_mfu | input | 1 | 0: evict lowest count, 1: evict highest count |
| decay_en | input | 1 | Enables periodic halving of counts |
| ref_valid | input | 1 | A reference is presented this cycle |
| ref_page | input | PAGE_W | Page number referenced |
| res_valid | output | 1 | Result fields are valid |
| res_hit | output | 1 | Page was resident |
| res_frame | output | $clog2(NFRAMES) | Frame holding or receiving the page |
| res_evict | output | 1 | A resident page was displaced |
| res_victim | output | PAGE_W | Page number displaced |
| fault_count | output | FC_W | Total faults since reset |

## Verification
A decay tick and a hit can fall in the same cycle. The tick would halve the hit page's count, and the hit would raise it. The bench brings this about by enabling decay and presenting a hit on exactly the sixteenth enabled edge. In that setup, the correct combined result (halved then incremented) is the only outcome under which a later most-frequently-used fault picks that page. If the increment were lost, a count tie would send the eviction to an older frame instead.

// File: rtl/freq_page_repl.sv
module freq_page_repl #(
  parameter int NFRAMES      = 3,
  parameter int PAGE_W       = 8,
  parameter int CNT_W        = 4,
  parameter int SEQ_W        = 16,
  parameter int FC_W         = 16,
  parameter int DECAY_PERIOD = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       mode_mfu,
  input  logic                       decay_en,
  input  logic                       ref_valid,
  input  logic [PAGE_W-1:0]          ref_page,
  output logic                       res_valid,
  output logic                       res_hit,
  output logic [$clog2(NFRAMES)-1:0] res_frame,
  output logic                       res_evict,
  output logic [PAGE_W-1:0]          res_victim,
  output logic [FC_W-1:0]            fault_count
);
  localparam int IDX_W = $clog2(NFRAMES);
  localparam int DCW   = $clog2(DECAY_PERIOD + 1);
  localparam logic [DCW-1:0]   DLAST   = DCW'(DECAY_PERIOD - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [PAGE_W-1:0] pg_q    [NFRAMES];
  logic [CNT_W-1:0]  cnt_q   [NFRAMES];
  logic [CNT_W-1:0]  cnt_base[NFRAMES];
  logic [SEQ_W-1:0]  stamp_q [NFRAMES];
  logic [NFRAMES-1:0] valid_q, hit_vec;
  logic [SEQ_W-1:0]  seq_q;
  logic [DCW-1:0]    dcnt_q;
  logic [IDX_W-1:0]  hit_idx, empty_idx, vic_idx, tgt_idx;
  logic              hit_any, full, tick;

  assign tick    = decay_en && (dcnt_q == DLAST);
  assign hit_any = |hit_vec;
  assign full    = &valid_q;
  assign tgt_idx = hit_any ? hit_idx : (full ? vic_idx : empty_idx);

  always_comb begin
    hit_idx   = '0;
    empty_idx = '0;
    for (int i = NFRAMES - 1; i >= 0; i--) begin
      hit_vec[i] = valid_q[i] && (pg_q[i] == ref_page);
      if (hit_vec[i])  hit_idx   = IDX_W'(i);
      if (!valid_q[i]) empty_idx = IDX_W'(i);
      if (tick && valid_q[i])
        cnt_base[i] = (cnt_q[i] > CNT_W'(3)) ? (cnt_q[i] >> 1) : CNT_ONE;
      else
        cnt_base[i] = cnt_q[i];
    end
  end

  always_comb begin
    vic_idx = '0;
    for (int i = 1; i < NFRAMES; i++) begin
      if ((mode_mfu ? (cnt_q[i] > cnt_q[vic_idx]) : (cnt_q[i] < cnt_q[vic_idx])) ||
          ((cnt_q[i] == cnt_q[vic_idx]) && (stamp_q[i] < stamp_q[vic_idx])))
        vic_idx = IDX_W'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q     <= '0;
      seq_q       <= '0;
      dcnt_q      <= '0;
      res_valid   <= 1'b0;
      res_hit     <= 1'b0;
      res_frame   <= '0;
      res_evict   <= 1'b0;
      res_victim  <= '0;
      fault_count <= '0;
      for (int i = 0; i < NFRAMES; i++) begin
        pg_q[i]    <= '0;
        cnt_q[i]   <= '0;
        stamp_q[i] <= '0;
      end
    end else begin
      dcnt_q    <= (!decay_en || tick) ? '0 : dcnt_q + 1'b1;
      res_valid <= ref_valid;
      for (int i = 0; i < NFRAMES; i++) begin
        cnt_q[i] <= cnt_base[i];
        if (ref_valid && (tgt_idx == IDX_W'(i))) begin
          if (hit_any) begin
            if (cnt_base[i] != CNT_MAX) cnt_q[i] <= cnt_base[i] + 1'b1;
          end else begin
            cnt_q[i]   <= CNT_ONE;
            pg_q[i]    <= ref_page;
            stamp_q[i] <= seq_q;
            valid_q[i] <= 1'b1;
          end
        end
      end
      if (ref_valid) begin
        res_hit    <= hit_any;
        res_frame  <= tgt_idx;
        res_evict  <= !hit_any && full;
        res_victim <= (!hit_any && full) ? pg_q[vic_idx] : '0;
        if (!hit_any) begin
          fault_count <= fault_count + 1'b1;
          seq_q       <= seq_q + 1'b1;
        end
      end
    end
  end

  p_result_follows_r6: assert property (@(posedge clk) disable iff (rst)
    ref_valid |=> res_valid);
  p_no_spurious_result_r6: assert property (@(posedge clk) disable iff (rst)
    !ref_valid |=> !res_valid);
  p_hit_no_evict_r1: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_hit) |-> !res_evict);
  p_fault_tally_r7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (fault_count == $past(fault_count) + 1'b1));
  p_hit_tally_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_hit) |-> $stable(fault_count));
  p_evict_only_when_full_r2: assert property (@(posedge clk) disable iff (rst)
    (ref_valid && !hit_any && !full) |=> !res_evict);
  p_unique_residency_r1: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));
  p_frame_in_range_r2: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_frame < IDX_W'(NFRAMES)));

  for (genvar g = 0; g < NFRAMES; g++) begin : g_chk
    p_count_floor_r9: assert property (@(posedge clk) disable iff (rst)
      valid_q[g] |-> (cnt_q[g] != '0));
  end
endmodule

// File: tb/freq_page_repl_tb.sv
module freq_page_repl_tb;
  logic       clk = 1'b0;
  logic       rst, mode_mfu, decay_en, ref_valid;
  logic [7:0] ref_page;
  logic       res_valid, res_hit, res_evict;
  logic [1:0] res_frame;
  logic [7:0] res_victim;
  logic [15:0] fault_count;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  freq_page_repl u_dut (
    .clk(clk), .rst(rst), .mode_mfu(mode_mfu), .decay_en(decay_en),
    .ref_valid(ref_valid), .ref_page(ref_page), .res_valid(res_valid),
    .res_hit(res_hit), .res_frame(res_frame), .res_evict(res_evict),
    .res_victim(res_victim), .fault_count(fault_count)
  );

  // {page, hit, frame, evict, victim, faults} in hex nibbles 2,1,1,1,2,1
  localparam logic [31:0] VEC [12] = '{
    32'h07_0_0_0_00_1, 32'h00_0_1_0_00_2, 32'h01_0_2_0_00_3, 32'h02_0_0_1_07_4,
    32'h00_1_1_0_00_4, 32'h03_0_2_1_01_5, 32'h00_1_1_0_00_5, 32'h04_0_0_1_02_6,
    32'h00_1_1_0_00_6, 32'h03_1_2_0_00_6, 32'h00_1_1_0_00_6, 32'h02_0_0_1_04_7
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; ref_valid = 0; decay_en = 0;
    @(posedge clk); @(negedge clk);
    rst = 0;
  endtask

  // called at a negedge, returns at the next negedge
  task automatic access(input logic [7:0] pg, input bit exp_hit, input int exp_frame,
                        input bit exp_evict, input logic [7:0] exp_victim, input string tag);
    ref_valid = 1; ref_page = pg;
    @(posedge clk); #1;
    ref_valid = 0;
    chk(res_valid === 1'b1, {tag, " valid"}, res_valid, 1);
    chk(res_hit === exp_hit, {tag, " hit"}, res_hit, exp_hit);
    chk(res_frame == exp_frame[1:0], {tag, " frame"}, res_frame, exp_frame);
    chk(res_evict === exp_evict, {tag, " evict"}, res_evict, exp_evict);
    if (exp_evict) chk(res_victim == exp_victim, {tag, " victim"}, res_victim, exp_victim);
    @(negedge clk);
  endtask

  task automatic touch(input logic [7:0] pg, input int times);
    for (int k = 0; k < times; k++) begin
      ref_valid = 1; ref_page = pg;
      @(posedge clk); #1; ref_valid = 0;
      @(negedge clk);
    end
  endtask

  initial begin
    #1_000_000;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    n_run++; n_fail++;
    report();
  end

  initial begin
    rst = 1; mode_mfu = 0; decay_en = 0; ref_valid = 0; ref_page = '0;
    do_reset();
    // R10 reset state
    chk(res_valid === 1'b0, "R10 res_valid after reset", res_valid, 0);
    chk(fault_count == 0, "R10 fault_count after reset", fault_count, 0);

    // R3 R5 LFU reference string, 3 frames
    for (int v = 0; v < 12; v++) begin
      access(VEC[v][31:24], VEC[v][20], int'(VEC[v][17:16]), VEC[v][12], VEC[v][11:4],
             $sformatf("R3/R5 ref#%0d", v));
      chk(fault_count == VEC[v][3:0], "R7 fault tally", fault_count, VEC[v][3:0]);
    end
    chk(fault_count == 7, "R5 total faults", fault_count, 7);

    // R6 idle cycle produces no result
    @(posedge clk); #1;
    chk(res_valid === 1'b0, "R6 idle no result", res_valid, 0);
    @(negedge clk);

    // R10 mid-run reset restarts at frame 0
    do_reset();
    access(8'd7, 0, 0, 0, 0, "R10 first load after reset");
    chk(fault_count == 1, "R10 tally restarts", fault_count, 1);

    // R4 MFU
    do_reset(); mode_mfu = 1;
    access(8'd10, 0, 0, 0, 0, "R2 fill f0");
    access(8'd11, 0, 1, 0, 0, "R2 fill f1");
    access(8'd12, 0, 2, 0, 0, "R2 fill f2");
    access(8'd11, 1, 1, 0, 0, "R1 hit");
    touch(8'd11, 1); touch(8'd10, 1);
    access(8'd13, 0, 1, 1, 8'd11, "R4 evict largest");
    access(8'd14, 0, 0, 1, 8'd10, "R4 evict next largest");

    // R8 saturation: wrap would make page 20 smallest
    do_reset(); mode_mfu = 1;
    touch(8'd20, 1); touch(8'd21, 1); touch(8'd22, 1);
    touch(8'd20, 15); touch(8'd22, 14);
    access(8'd23, 0, 0, 1, 8'd20, "R8 saturated tie");

    // R9 decay lets an old busy page become the LFU victim
    do_reset(); mode_mfu = 0;
    touch(8'd30, 1); touch(8'd31, 1); touch(8'd32, 1);
    touch(8'd30, 6);
    decay_en = 1;
    repeat (48) @(posedge clk);
    @(negedge clk); decay_en = 0;
    access(8'd33, 0, 0, 1, 8'd30, "R9 decayed page evicted");

    // R9 decay tick coincident with a hit
    do_reset(); mode_mfu = 1;
    touch(8'd40, 1); touch(8'd41, 1); touch(8'd42, 1);
    touch(8'd40, 1); touch(8'd41, 2);
    decay_en = 1;
    repeat (15) @(posedge clk);
    @(negedge clk);
    access(8'd41, 1, 1, 0, 0, "R9 hit on tick");
    decay_en = 0;
    access(8'd43, 0, 1, 1, 8'd41, "R9 halved plus one");

    report();
  end
endmodule